// File: doc/BRIEF.md
# CAN Initialization and Configuration Gate

This block holds the mode bits that decide whether a CAN controller is allowed onto the bus. One bit selects initialization mode. A second bit, the configuration-change enable, unlocks the bit timing register. A bank of per-object valid flags decides which message objects may take part in communication.

While initialization mode is active, the block does three things:
- it holds the transmit pin recessive (high);
- it blocks every message transfer;
- it leaves every configuration register exactly as it was.

After the host clears initialization mode, the block watches the receive line. It enables transfer only once the bus has been seen idle: a run of consecutive recessive bits, modelled as one bit per clock.

The host reaches the block over a simple word bus. Writes take effect on the clock edge. Reads are combinational from the address. The bit timing contents are also driven out as a port for the timing engine.

Top module: `can_init_gate`

## Requirements
- R1: Register map: address 0 is control, where bit 0 is the initialization bit and bit 1 is the configuration-change enable. Address 1 is the 16-bit bit timing register. Address 2 holds the 32 object valid flags. Address 3 reads 0. After reset, control reads 1 (initialization on, enable off) and bit timing reads 0x2301.
- R2: While the initialization bit is 1, `can_tx` is 1 whatever `proto_tx` is. While the initialization bit is 0, `can_tx` equals `proto_tx` in the same cycle.
- R3: While the initialization bit is 1, `xfer_en` is 0 and every bit of `obj_act` is 0.
- R4: Writing the control register, including setting the initialization bit, leaves the bit timing register and the valid flags unchanged.
- R5: A write to the bit timing register is stored only if the initialization bit and the enable bit are both 1 before the write. Otherwise the write is ignored and the old value remains.
- R6: The enable bit can be written and read back whatever the initialization bit is.
- R7: All valid flags reset to 0. Writes to address 2 are accepted in any mode. `obj_act[i]` is 1 only when flag i is 1 and `xfer_en` is 1.
- R8: After the initialization bit is cleared, `xfer_en` becomes 1 after 11 consecutive clock edges that sample `bus_rx` at 1. A 0 on `bus_rx` before that restarts the count.
- R9: The bit timing register reads back its stored value in every combination of the two control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from `reg_addr` |
| proto_tx | input | 1 | Transmit bit from the protocol engine |
| bus_rx | input | 1 | Receive line, one sample per bit |
| can_tx | output | 1 | Transmit pin |
| xfer_en | output | 1 | Message transfer allowed |
| bt_cfg | output | 16 | Bit timing register contents |
| obj_valid | output | 32 | Per-object valid flags |
| obj_act | output | 32 | Objects currently allowed to communicate |

## Verification
Register writes become visible one edge after the strobe. Reads and `can_tx` are combinational. `xfer_en` rises at the eleventh edge after the edge that clears initialization, or after the edge at which the receive line returns to 1.

The bench drives inputs at the falling edge and samples combinational results shortly after that edge. For the idle count it checks both the tenth and the eleventh falling edge after the relevant write, so a count that is off by one in either direction is caught.

// File: rtl/can_gate_pkg.sv
// Package: shared register selects and control-bit positions for the
// CAN initialization gate. Assumes a 2-bit word address.
package can_gate_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_TIMING = 2'd1,
        SEL_VALID  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int CTL_INIT_POS = 0;
    localparam int CTL_CFG_POS  = 1;
endpackage

// File: rtl/can_mode_regs.sv
// can_mode_regs: holds the initialization bit, the configuration-change
// enable and the bit timing register. The timing register accepts a
// write only while both control bits are already set. Assumes a
// synchronous active-low reset; initialization mode is the reset state.
module can_mode_regs
    import can_gate_pkg::*;
#(
    parameter int          BT_W     = 16,
    parameter logic [15:0] BT_RESET = 16'h2301
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        wr_sel,
    input  logic [BT_W-1:0] wr_data,
    output logic            init_o,
    output logic            cfg_o,
    output logic [BT_W-1:0] bt_o
);
    logic            init_q;
    logic            cfg_q;
    logic [BT_W-1:0] bt_q;
    logic            bt_unlocked;

    // Timing writes are open only while both control bits hold 1.
    assign bt_unlocked = init_q & cfg_q;

    // Control register: mode bits, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b1;
            cfg_q  <= 1'b0;
        end else if (wr_en && wr_sel == SEL_CTRL) begin
            init_q <= wr_data[CTL_INIT_POS];
            cfg_q  <= wr_data[CTL_CFG_POS];
        end
    end

    // Bit timing register: write-protected outside the unlocked state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bt_q <= BT_RESET[BT_W-1:0];
        end else if (wr_en && wr_sel == SEL_TIMING && bt_unlocked) begin
            bt_q <= wr_data;
        end
    end

    assign init_o = init_q;
    assign cfg_o  = cfg_q;
    assign bt_o   = bt_q;

    AST_INIT_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> init_q); // R1
    AST_BT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_q && cfg_q) |=> $stable(bt_q)); // R5
    AST_CTRL_KEEPS_BT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> $stable(bt_q)); // R4
endmodule

// File: rtl/can_idle_detect.sv
// can_idle_detect: after initialization is left, counts consecutive
// recessive samples on the receive line and raises transfer enable once
// IDLE_BITS of them are seen in a row. Assumes one sample per bit time.
module can_idle_detect #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic bus_rx,
    output logic xfer_en
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);

    logic [CNT_W-1:0] run_q;
    logic             en_q;

    // Idle-run counter: restarts on a dominant bit, holds once enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            run_q <= '0;
            en_q  <= 1'b0;
        end else if (!en_q) begin
            if (!bus_rx) begin
                run_q <= '0;
            end else if (run_q == CNT_W'(IDLE_BITS - 1)) begin
                en_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // Enable is masked at once when initialization is entered again.
    assign xfer_en = en_q & ~init;

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CNT_W'(IDLE_BITS)); // R8
    AST_EN_AFTER_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(bus_rx)); // R8
endmodule

// File: rtl/can_obj_flags.sv
// can_obj_flags: one valid flag per message object, cleared at reset and
// written as a word by the host. An object is active only when valid
// and transfer is enabled.
module can_obj_flags
    import can_gate_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [NUM_OBJ-1:0] wr_data,
    input  logic               xfer_en,
    output logic [NUM_OBJ-1:0] valid_o,
    output logic [NUM_OBJ-1:0] act_o
);
    logic wr_hit;

    assign wr_hit = wr_en && (wr_sel == SEL_VALID);

    for (genvar i = 0; i < NUM_OBJ; i++) begin : g_obj
        logic vld_q;
        // Per-object valid flag, not valid after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (wr_hit) begin
                vld_q <= wr_data[i];
            end
        end
        assign valid_o[i] = vld_q;
        assign act_o[i]   = vld_q & xfer_en;
    end

    AST_VALID_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> valid_o == '0); // R7
endmodule

// File: rtl/can_init_gate.sv
// can_init_gate: top of the CAN initialization/configuration gate.
// Holds the mode bits, locks the bit timing register, forces the
// transmit pin recessive in initialization mode and gates transfer on
// bus idle. Reads are combinational from the address.
module can_init_gate
    import can_gate_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          BT_W      = 16,
    parameter logic [15:0] BT_RESET  = 16'h2301,
    parameter int          NUM_OBJ   = 32,
    parameter int          IDLE_BITS = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               proto_tx,
    input  logic               bus_rx,
    output logic               can_tx,
    output logic               xfer_en,
    output logic [BT_W-1:0]    bt_cfg,
    output logic [NUM_OBJ-1:0] obj_valid,
    output logic [NUM_OBJ-1:0] obj_act
);
    reg_sel_e sel;
    logic     init_m;
    logic     cfg_m;

    assign sel = reg_sel_e'(reg_addr);

    can_mode_regs #(.BT_W(BT_W), .BT_RESET(BT_RESET)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_sel (sel),
        .wr_data(reg_wdata[BT_W-1:0]),
        .init_o (init_m),
        .cfg_o  (cfg_m),
        .bt_o   (bt_cfg)
    );

    can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (init_m),
        .bus_rx (bus_rx),
        .xfer_en(xfer_en)
    );

    can_obj_flags #(.NUM_OBJ(NUM_OBJ)) u_obj (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_sel (sel),
        .wr_data(reg_wdata[NUM_OBJ-1:0]),
        .xfer_en(xfer_en),
        .valid_o(obj_valid),
        .act_o  (obj_act)
    );

    // Transmit pin: recessive during initialization, else the engine bit.
    assign can_tx = init_m | proto_tx;

    // Host read mux: every register is readable in every mode.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                reg_rdata[CTL_INIT_POS] = init_m;
                reg_rdata[CTL_CFG_POS]  = cfg_m;
            end
            SEL_TIMING: reg_rdata[BT_W-1:0]    = bt_cfg;
            SEL_VALID:  reg_rdata[NUM_OBJ-1:0] = obj_valid;
            default:    reg_rdata = '0;
        endcase
    end

    AST_TX_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        init_m |-> can_tx); // R2
    AST_NO_XFER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        init_m |-> (!xfer_en && obj_act == '0)); // R3
    AST_ACT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (obj_act & ~obj_valid) == '0); // R7
endmodule

// File: tb/can_init_gate_test.sv
module can_init_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        proto_tx = 1'b1;
    logic        bus_rx = 1'b1;
    logic        can_tx;
    logic        xfer_en;
    logic [15:0] bt_cfg;
    logic [31:0] obj_valid;
    logic [31:0] obj_act;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    can_init_gate uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .proto_tx(proto_tx),
        .bus_rx(bus_rx), .can_tx(can_tx), .xfer_en(xfer_en), .bt_cfg(bt_cfg),
        .obj_valid(obj_valid), .obj_act(obj_act)
    );

    // {ctrl[1:0], timing write data, expected timing afterwards}
    localparam logic [33:0] VEC [6] = '{
        {2'b11, 16'h1111, 16'h1111},
        {2'b01, 16'h2222, 16'h1111},
        {2'b10, 16'h3333, 16'h1111},
        {2'b00, 16'h4444, 16'h1111},
        {2'b11, 16'hBEEF, 16'hBEEF},
        {2'b11, 16'h0000, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, r); chk("R1 ctrl", r, 32'h1);
        rd(2'd1, r); chk("R1 timing", r, 32'h2301);
        rd(2'd3, r); chk("R1 unused addr", r, 32'h0);
        rd(2'd2, r); chk("R7 valid reset", r, 32'h0);
        chk("R3 xfer reset", {31'd0, xfer_en}, 32'h0);
        proto_tx = 1'b0; #1;
        chk("R2 tx in init", {31'd0, can_tx}, 32'h1);

        // Table walk: R5 write lock, R9 reads, R2 pin, R6 enable readback
        for (int k = 0; k < 6; k++) begin
            wr(2'd0, {30'd0, VEC[k][33:32]});
            rd(2'd0, r); chk("R6 ctrl readback", r, {30'd0, VEC[k][33:32]});
            wr(2'd1, {16'd0, VEC[k][31:16]});
            rd(2'd1, r); chk("R5/R9 timing", r, {16'd0, VEC[k][15:0]});
            chk("R2 tx pin", {31'd0, can_tx}, {31'd0, VEC[k][32]});
        end

        // R4: entering init keeps timing and valid flags
        wr(2'd2, 32'hA5A5_0F0F);
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h1);
        rd(2'd1, r); chk("R4 timing kept", r, 32'h0000);
        rd(2'd2, r); chk("R4 valid kept", r, 32'hA5A5_0F0F);
        chk("R3 no act in init", obj_act, 32'h0);

        // R8: idle count after clearing init
        bus_rx = 1'b1;
        wr(2'd0, 32'h0);
        proto_tx = 1'b0; #1;
        chk("R2 tx follows engine", {31'd0, can_tx}, 32'h0);
        proto_tx = 1'b1;
        wait_neg(10);
        chk("R8 not yet at 10", {31'd0, xfer_en}, 32'h0);
        wait_neg(1);
        chk("R8 enabled at 11", {31'd0, xfer_en}, 32'h1);
        chk("R7 act = valid", obj_act, 32'hA5A5_0F0F);

        // R3: re-entering init drops transfer at once
        wr(2'd0, 32'h1);
        chk("R3 xfer off in init", {31'd0, xfer_en}, 32'h0);
        chk("R3 act off in init", obj_act, 32'h0);

        // R8 restart: a dominant bit resets the run
        wr(2'd0, 32'h0);
        wait_neg(4);
        bus_rx = 1'b0;
        wait_neg(1);
        bus_rx = 1'b1;
        wait_neg(10);
        chk("R8 restart not yet", {31'd0, xfer_en}, 32'h0);
        wait_neg(1);
        chk("R8 restart enabled", {31'd0, xfer_en}, 32'h1);

        // R7: valid flags written while transferring
        wr(2'd2, 32'h0000_0003);
        chk("R7 act update", obj_act, 32'h3);
        chk("R7 valid port", obj_valid, 32'h3);
        rd(2'd1, r); chk("R9 read in run mode", r, 32'h0000);
        chk("R5 bt port", {16'd0, bt_cfg}, 32'h0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule